// File: doc/BRIEF.md
# Base-Addressed On-Chip SRAM Window

This block places a 4 KB on-chip SRAM behind one programmable base register. Software sets the window's base address, an enable bit, a write-protect bit and five per-address-space inhibit bits through a plain register port. Every bus request carries an address, an address-space code, a direction flag, byte enables and write data.

The block decides whether the request belongs to the SRAM. A request belongs only if the window is enabled, the upper address bits match the programmed base, the unused bits below the base are zero, and the address space of the request is not inhibited. A matching read returns a word from the array. A matching write stores the enabled bytes, or reports an access error when the window is write-protected. Every other request is flagged as a miss so that the surrounding fabric can route it elsewhere. Each request gets one response strobe, one cycle later.

Top module: `sramw_top`

## Requirements
- R1: After reset the configuration register reads as zero, so the window is disabled and every request misses. The array contents are not cleared by reset.
- R2: The configuration register stores and reads back bits 31:15 (base), bit 8 (write protect), bits 5:1 (space inhibits) and bit 0 (enable). Every other bit reads as zero, so writing all ones reads back 0xFFFF_813F.
- R3: While bit 0 of the configuration register is 0, every request gets a miss response and no array access. Setting the bit again exposes the earlier array contents.
- R4: A request can hit only when request address bits 31:15 equal configuration bits 31:15.
- R5: A request can hit only when request address bits 14:12 are all zero. Otherwise it misses.
- R6: Space codes are 0 user data, 1 user code, 2 supervisor data, 3 supervisor code and 4 CPU-space/interrupt-acknowledge. They are inhibited by configuration bits 1, 2, 3, 4 and 5 respectively. An inhibited request misses. Codes 5 to 7 always miss.
- R7: A hitting write with bit 8 clear writes the 32-bit array word indexed by address bits 11:2. Byte enable bit i updates data bits 8i+7:8i. Address bits 1:0 are ignored, and a later hitting read returns the merged word.
- R8: A hitting write with bit 8 set gives an error response and leaves the array unchanged.
- R9: A hitting read returns the array word whatever the state of bit 8.
- R10: Each request sampled with `req_valid` high gets exactly one of `rsp_ready`, `rsp_err` or `rsp_miss` on the next cycle. A cycle without a request is followed by none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration register readback |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_space | input | 3 | Address-space code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Hit completed; read data valid for reads |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` after a read |
| rsp_err | output | 1 | Write-protect access error |
| rsp_miss | output | 1 | Request is not an SRAM reference |

## Verification
The bound checker checks on every cycle that the three response strobes are mutually exclusive and appear only after a request. It also checks that a disabled window, nonzero bits 14:12 and a protected write never produce a normal completion, and that the register is zero after reset. What only the bench scenarios can show is data behaviour. That covers byte-lane merging, the word index, the array keeping its contents across a rejected write or a disable period, and the correct pairing of each space code with its inhibit bit.

// File: rtl/sramw_pkg.sv
package sramw_pkg;
  localparam int ENABLE_BIT = 0;
  localparam int INHIBIT_LSB = 1;
  localparam int NUM_SPACES = 5;
  localparam int WPROT_BIT = 8;

  typedef enum logic [2:0] {
    SP_USER_DATA = 3'd0,
    SP_USER_CODE = 3'd1,
    SP_SUPV_DATA = 3'd2,
    SP_SUPV_CODE = 3'd3,
    SP_CPU_IACK  = 3'd4
  } space_e;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_DONE = 2'd1,
    OUT_ERR  = 2'd2,
    OUT_MISS = 2'd3
  } outcome_e;
endpackage

// File: rtl/sramw_basereg.sv
module sramw_basereg
  import sramw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          wdata,
  output logic [ADDR_W-1:0]          rdata,
  output logic [ADDR_W-BASE_LSB-1:0] base,
  output logic                       enable,
  output logic                       wprot,
  output logic [NUM_SPACES-1:0]      inhibit
);
  localparam int BASE_W = ADDR_W - BASE_LSB;

  always_ff @(posedge clk) begin
    if (rst) begin
      base    <= '0;
      enable  <= 1'b0;
      wprot   <= 1'b0;
      inhibit <= '0;
    end else if (we) begin
      base    <= wdata[ADDR_W-1:BASE_LSB];
      enable  <= wdata[ENABLE_BIT];
      wprot   <= wdata[WPROT_BIT];
      inhibit <= wdata[INHIBIT_LSB +: NUM_SPACES];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[ADDR_W-1:BASE_LSB] = base;
    rdata[WPROT_BIT] = wprot;
    rdata[INHIBIT_LSB +: NUM_SPACES] = inhibit;
    rdata[ENABLE_BIT] = enable;
  end

  logic unused_w;
  assign unused_w = ^{BASE_W};
endmodule

// File: rtl/sramw_decode.sv
module sramw_decode
  import sramw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 15,
  parameter int WIN_BITS = 12
) (
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [2:0]                 req_space,
  input  logic                       req_write,
  input  logic [ADDR_W-BASE_LSB-1:0] base,
  input  logic                       enable,
  input  logic                       wprot,
  input  logic [NUM_SPACES-1:0]      inhibit,
  output logic                       array_en,
  output logic                       array_wr,
  output outcome_e                   outcome
);
  logic gap_zero;
  logic base_eq;
  logic space_ok;
  logic hit;
  logic [NUM_SPACES-1:0] space_oh;

  generate
    if (BASE_LSB > WIN_BITS) begin : g_gap
      assign gap_zero = (req_addr[BASE_LSB-1:WIN_BITS] == '0);
    end else begin : g_nogap
      assign gap_zero = 1'b1;
    end
  endgenerate

  assign base_eq  = (req_addr[ADDR_W-1:BASE_LSB] == base);
  assign space_oh = NUM_SPACES'(1) << req_space;
  assign space_ok = (req_space < 3'(NUM_SPACES)) && ((space_oh & inhibit) == '0);
  assign hit      = enable && base_eq && gap_zero && space_ok;

  always_comb begin
    array_en = 1'b0;
    array_wr = 1'b0;
    outcome  = OUT_NONE;
    if (req_valid) begin
      if (!hit) begin
        outcome = OUT_MISS;
      end else if (req_write && wprot) begin
        outcome = OUT_ERR;
      end else begin
        outcome  = OUT_DONE;
        array_en = 1'b1;
        array_wr = req_write;
      end
    end
  end
endmodule

// File: rtl/sramw_array.sv
module sramw_array #(
  parameter int WORDS = 1024,
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               en,
  input  logic               wr,
  input  logic [LANES-1:0]   be,
  input  logic [IDX_W-1:0]   idx,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] mem [WORDS];
      always_ff @(posedge clk) begin
        if (en) begin
          if (wr && be[g]) begin
            mem[idx] <= wdata[8*g +: 8];
          end
          rdata[8*g +: 8] <= mem[idx];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sramw_top.sv
module sramw_top
  import sramw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BASE_LSB = 15,
  parameter int WIN_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_space,
  input  logic              req_write,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_miss
);
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int WORDS  = (1 << WIN_BITS) / LANES;
  localparam int IDX_W  = $clog2(WORDS);

  logic [ADDR_W-BASE_LSB-1:0] base;
  logic enable;
  logic wprot;
  logic [NUM_SPACES-1:0] inhibit;
  logic array_en;
  logic array_wr;
  outcome_e outcome;

  sramw_basereg #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_reg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .base(base), .enable(enable), .wprot(wprot), .inhibit(inhibit)
  );

  sramw_decode #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .WIN_BITS(WIN_BITS)) u_dec (
    .req_valid(req_valid), .req_addr(req_addr), .req_space(req_space),
    .req_write(req_write), .base(base), .enable(enable), .wprot(wprot),
    .inhibit(inhibit), .array_en(array_en), .array_wr(array_wr), .outcome(outcome)
  );

  sramw_array #(.WORDS(WORDS), .LANES(LANES)) u_mem (
    .clk(clk), .en(array_en), .wr(array_wr), .be(req_be),
    .idx(req_addr[OFF_W +: IDX_W]), .wdata(req_wdata), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_ready <= (outcome == OUT_DONE);
      rsp_err   <= (outcome == OUT_ERR);
      rsp_miss  <= (outcome == OUT_MISS);
    end
  end
endmodule

// File: rtl/sramw_checker.sv
module sramw_checker #(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 15,
  parameter int WIN_BITS = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic [ADDR_W-1:0] cfg_rdata,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic              rsp_miss
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_rdata == '0));

  assert_disabled_miss_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cfg_rdata[0]) |=> rsp_miss);

  assert_gap_miss_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_addr[BASE_LSB-1:WIN_BITS] != '0)) |=> rsp_miss);

  assert_protect_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && cfg_rdata[8]) |=> !rsp_ready);

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_ready, rsp_err, rsp_miss}));

  assert_req_gets_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_ready || rsp_err || rsp_miss));

  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_ready || rsp_err || rsp_miss));
endmodule

bind sramw_top sramw_checker #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .cfg_rdata(cfg_rdata), .rsp_ready(rsp_ready),
  .rsp_err(rsp_err), .rsp_miss(rsp_miss)
);

// File: tb/test_sramw_top.sv
module test_sramw_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0] req_space = '0;
  logic req_write = 1'b0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready, rsp_err, rsp_miss;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sramw_top i_sramw_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_space(req_space),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_miss(rsp_miss)
  );

  // expected kind: 0 done, 1 error, 2 miss
  typedef struct packed {
    logic        cfg_en;
    logic [31:0] cfg;
    logic        wr;
    logic [2:0]  sp;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [1:0]  ek;
    logic [31:0] ed;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h2000_8001, 1'b1, 3'd0, 32'h2000_8010, 4'hF, 32'hA5A5_1234, 2'd0, 32'h0, 4'd7},          // R7 full write
    '{1'b0, 32'h0, 1'b0, 3'd2, 32'h2000_8010, 4'hF, 32'h0, 2'd0, 32'hA5A5_1234, 4'd7},                   // R7 read back
    '{1'b0, 32'h0, 1'b1, 3'd0, 32'h2000_8010, 4'b0100, 32'h00EE_0000, 2'd0, 32'h0, 4'd7},               // R7 one lane
    '{1'b0, 32'h0, 1'b0, 3'd2, 32'h2000_8013, 4'hF, 32'h0, 2'd0, 32'hA5EE_1234, 4'd7},                   // R7 merge, low bits ignored
    '{1'b0, 32'h0, 1'b1, 3'd3, 32'h2000_8FFC, 4'hF, 32'hDEAD_BEEF, 2'd0, 32'h0, 4'd7},                   // R7 top word
    '{1'b0, 32'h0, 1'b0, 3'd4, 32'h2000_8FFC, 4'hF, 32'h0, 2'd0, 32'hDEAD_BEEF, 4'd7},
    '{1'b0, 32'h0, 1'b0, 3'd0, 32'h2000_9000, 4'hF, 32'h0, 2'd2, 32'h0, 4'd5},                           // R5 bit 12
    '{1'b0, 32'h0, 1'b0, 3'd0, 32'h2000_FFFC, 4'hF, 32'h0, 2'd2, 32'h0, 4'd5},                           // R5 bit 14
    '{1'b0, 32'h0, 1'b0, 3'd0, 32'h2000_0010, 4'hF, 32'h0, 2'd2, 32'h0, 4'd4},                           // R4 bit 15
    '{1'b0, 32'h0, 1'b0, 3'd0, 32'hA000_8010, 4'hF, 32'h0, 2'd2, 32'h0, 4'd4},                           // R4 bit 31
    '{1'b0, 32'h0, 1'b0, 3'd5, 32'h2000_8010, 4'hF, 32'h0, 2'd2, 32'h0, 4'd6},                           // R6 code 5
    '{1'b0, 32'h0, 1'b0, 3'd7, 32'h2000_8010, 4'hF, 32'h0, 2'd2, 32'h0, 4'd6},                           // R6 code 7
    '{1'b1, 32'h2000_8003, 1'b0, 3'd0, 32'h2000_8010, 4'hF, 32'h0, 2'd2, 32'h0, 4'd6},                   // R6 user data inhibited
    '{1'b0, 32'h0, 1'b0, 3'd1, 32'h2000_8010, 4'hF, 32'h0, 2'd0, 32'hA5EE_1234, 4'd6},                   // R6 user code allowed
    '{1'b1, 32'h2000_8009, 1'b0, 3'd2, 32'h2000_8010, 4'hF, 32'h0, 2'd2, 32'h0, 4'd6},                   // R6 supv data inhibited
    '{1'b0, 32'h0, 1'b0, 3'd3, 32'h2000_8010, 4'hF, 32'h0, 2'd0, 32'hA5EE_1234, 4'd6},                   // R6 supv code allowed
    '{1'b1, 32'h2000_8021, 1'b0, 3'd4, 32'h2000_8010, 4'hF, 32'h0, 2'd2, 32'h0, 4'd6},                   // R6 cpu space inhibited
    '{1'b1, 32'h2000_8101, 1'b1, 3'd0, 32'h2000_8010, 4'hF, 32'h1111_1111, 2'd1, 32'h0, 4'd8},           // R8 protected write
    '{1'b0, 32'h0, 1'b0, 3'd0, 32'h2000_8010, 4'hF, 32'h0, 2'd0, 32'hA5EE_1234, 4'd9},                   // R9 read while protected
    '{1'b0, 32'h0, 1'b1, 3'd1, 32'h2000_8FFC, 4'hF, 32'h0, 2'd1, 32'h0, 4'd8},                           // R8
    '{1'b0, 32'h0, 1'b0, 3'd1, 32'h2000_8FFC, 4'hF, 32'h0, 2'd0, 32'hDEAD_BEEF, 4'd9},                   // R9
    '{1'b1, 32'h2000_8000, 1'b0, 3'd0, 32'h2000_8010, 4'hF, 32'h0, 2'd2, 32'h0, 4'd3},                   // R3 disabled
    '{1'b1, 32'h2000_8001, 1'b0, 3'd0, 32'h2000_8010, 4'hF, 32'h0, 2'd0, 32'hA5EE_1234, 4'd3}            // R3 re-enabled keeps data
  };

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_cfg(input int rq, input logic [31:0] exp);
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL R%0d: cfg_rdata actual %h expected %h", rq, cfg_rdata, exp);
    end
  endtask

  // issues one request; outputs sampled at the negedge after the capturing posedge
  task automatic access(input logic wr, input logic [2:0] sp, input logic [31:0] a,
                        input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_space = sp;
    req_addr = a;
    req_be = be;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_rsp(input int rq, input logic [1:0] ek, input logic rd, input logic [31:0] ed);
    logic [2:0] exp_s;
    exp_s = (ek == 2'd0) ? 3'b100 : (ek == 2'd1) ? 3'b010 : 3'b001;
    checks++;
    if ({rsp_ready, rsp_err, rsp_miss} !== exp_s) begin
      errors++;
      $display("FAIL R%0d: strobes ready/err/miss actual %b expected %b", rq,
               {rsp_ready, rsp_err, rsp_miss}, exp_s);
    end else if (rd && ek == 2'd0 && rsp_rdata !== ed) begin
      errors++;
      $display("FAIL R%0d: rdata actual %h expected %h", rq, rsp_rdata, ed);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: register cleared, window disabled
    check_cfg(1, 32'h0);
    access(1'b0, 3'd0, 32'h0000_0000, 4'hF, 32'h0);
    check_rsp(1, 2'd2, 1'b0, 32'h0);
    // R10: no request, no strobe
    @(negedge clk);
    checks++;
    if ({rsp_ready, rsp_err, rsp_miss} !== 3'b000) begin
      errors++;
      $display("FAIL R10: idle strobes actual %b expected 000", {rsp_ready, rsp_err, rsp_miss});
    end
    // R2: implemented bits only
    cfg_write(32'hFFFF_FFFF);
    check_cfg(2, 32'hFFFF_813F);
    cfg_write(32'h0000_7EC0);
    check_cfg(2, 32'h0000_0000);
    cfg_write(32'h1234_8125);
    check_cfg(2, 32'h1234_8125);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].cfg_en) cfg_write(VEC[i].cfg);
      access(VEC[i].wr, VEC[i].sp, VEC[i].addr, VEC[i].be, VEC[i].wd);
      check_rsp(int'(VEC[i].rq), VEC[i].ek, !VEC[i].wr, VEC[i].ed);
    end

    // R1: reset does not clear array, but disables window
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_cfg(1, 32'h0);
    access(1'b0, 3'd0, 32'h2000_8010, 4'hF, 32'h0);
    check_rsp(1, 2'd2, 1'b0, 32'h0);
    cfg_write(32'h2000_8001);
    access(1'b0, 3'd0, 32'h2000_8010, 4'hF, 32'h0);
    check_rsp(1, 2'd0, 1'b1, 32'hA5EE_1234);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule